// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder

A flash converter's comparator bank produces a thermometer word. Every comparator whose threshold lies below the input voltage outputs a one. In a clean sample these ones form one unbroken run that begins at bit 0. This block turns that word into a binary count of the levels that are lit, and it flags any word that is not a legal thermometer pattern.

The block is purely combinational, and the parameter `THERM_W` sets the width. The default is 7 input bits, which gives a 3-bit result. A legal word lights the lowest k bits and leaves every bit above them clear, and it then encodes to k.

A bubble is a clear bit with a set bit somewhere above it. When a word contains a bubble, the block raises a flag. It still reports one more than the index of the highest set bit, so a stray gap in the run costs no range.

Top module: `therm_to_bin`

## Requirements
- R1: An all-zero input gives `level_out` = 0 with `bubble_flag` low.
- R2: A legal word whose lowest k bits are set and whose upper bits are clear (0 <= k <= THERM_W) gives `level_out` = k with `bubble_flag` low. There are exactly THERM_W+1 such words.
- R3: `bubble_flag` is high exactly when some clear input bit sits below a set input bit.
- R4: For an input that R3 flags, `level_out` equals the index of the highest set bit plus one. This value is strictly greater than the number of set bits.
- R5: `level_out` never exceeds THERM_W. Its width is ceil(log2(THERM_W+1)) bits, which is 3 bits for the default.
- R6: The block holds no state. Both outputs depend only on the present input and follow every input change with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| therm_in | input | THERM_W | Thermometer word from the comparator bank; bit 0 is the lowest threshold |
| level_out | output | $clog2(THERM_W+1) | Binary level count |
| bubble_flag | output | 1 | High when the input is not a legal thermometer word |

## Verification
On every input change, the assertions check several relations. A word that is not flagged must encode to its count of set bits, and zero must encode to zero. A flagged word must report more than its count of set bits, and the result must stay within range. The bench's directed scenarios must cover the rest. They confirm the exact highest-bit fallback for each illegal word and that the flag is raised for every non-legal pattern across all 128 inputs. They also confirm that each of the eight legal words maps to its own value.

// File: rtl/therm_to_bin.sv
module therm_to_bin #(
  parameter int THERM_W = 7,
  localparam int LVL_W = $clog2(THERM_W + 1)
) (
  input  logic [THERM_W-1:0] therm_in,
  output logic [LVL_W-1:0]   level_out,
  output logic               bubble_flag
);

  logic [LVL_W-1:0]   top_pos;
  logic [THERM_W-1:0] fill_mask;

  always_comb begin
    top_pos = '0;
    for (int i = 0; i < THERM_W; i++)
      if (therm_in[i]) top_pos = LVL_W'(i + 1);
  end

  always_comb begin
    for (int i = 0; i < THERM_W; i++)
      fill_mask[i] = (i < int'(top_pos));
  end

  assign level_out   = top_pos;
  assign bubble_flag = (therm_in != fill_mask);

  always_comb begin
    if (therm_in == '0)
      a_r1_zero_word: assert (level_out == '0 && !bubble_flag);
    if (!bubble_flag)
      a_r2_legal_count: assert (int'(level_out) == $countones(therm_in));
    if (bubble_flag)
      a_r4_above_popcount: assert (int'(level_out) > $countones(therm_in));
    a_r5_in_range: assert (int'(level_out) <= THERM_W);
  end

endmodule

// File: tb/tb_therm_to_bin.sv
module tb_therm_to_bin;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 7;
  localparam int LW = $clog2(TW + 1);

  logic          clk = 1'b0;
  logic [TW-1:0] therm_in = '0;
  logic [LW-1:0] level_out;
  logic          bubble_flag;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  therm_to_bin #(.THERM_W(TW)) dut (
    .therm_in(therm_in), .level_out(level_out), .bubble_flag(bubble_flag)
  );

  function automatic bit is_legal(input logic [TW-1:0] v);
    for (int k = 0; k <= TW; k++)
      if (v == TW'((1 << k) - 1)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int top_plus_one(input logic [TW-1:0] v);
    for (int i = TW - 1; i >= 0; i--)
      if (v[i]) return i + 1;
    return 0;
  endfunction

  task automatic apply(input logic [TW-1:0] v);
    @(posedge clk);
    therm_in = v;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input int lvl, input bit flg);
    checks++;
    if (int'(level_out) !== lvl || bubble_flag !== flg) begin
      fails++;
      $display("FAIL %s in=%b actual level=%0d flag=%0b expected level=%0d flag=%0b",
               req, therm_in, level_out, bubble_flag, lvl, flg);
    end
  endtask

  task automatic t_zero_word;
    apply('0);
    expect_out("R1", 0, 1'b0);
  endtask

  task automatic t_legal_words;
    for (int k = 0; k <= TW; k++) begin
      apply(TW'((1 << k) - 1));
      expect_out("R2", k, 1'b0);
    end
  endtask

  task automatic t_single_bubble;
    apply(7'b1111011);
    expect_out("R4", 7, 1'b1);
    apply(7'b0000110);
    expect_out("R3", 3, 1'b1);
    apply(7'b1000000);
    expect_out("R4", 7, 1'b1);
  endtask

  task automatic t_all_patterns;
    int legal_seen = 0;
    for (int v = 0; v < (1 << TW); v++) begin
      apply(TW'(v));
      if (is_legal(TW'(v))) legal_seen++;
      expect_out("R3", top_plus_one(TW'(v)), !is_legal(TW'(v)));
      checks++;
      if (int'(level_out) > TW) begin
        fails++;
        $display("FAIL R5 actual level=%0d expected <=%0d", level_out, TW);
      end
    end
    checks++;
    if (legal_seen != TW + 1) begin
      fails++;
      $display("FAIL R2 actual legal words=%0d expected %0d", legal_seen, TW + 1);
    end
  endtask

  task automatic t_no_clock_needed;
    therm_in = 7'b0011111;
    #1;
    expect_out("R6", 5, 1'b0);
    therm_in = 7'b0101111;
    #1;
    expect_out("R6", 6, 1'b1);
  endtask

  initial begin
    t_zero_word();
    t_legal_words();
    t_single_bubble();
    t_all_patterns();
    t_no_clock_needed();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule